// File: doc/BRIEF.md
# Short-Immediate Register Execute Unit

This unit executes one 16-bit instruction per clock. Each instruction names one register index and carries a 4-bit immediate. The unit holds two register files: sixteen 32-bit data registers and sixteen 32-bit address registers. In a single cycle it decodes the major opcode, reads its operands, computes the result and writes at most one register.

Data register 15 plays a special part. It is the condition tested by the conditional add and conditional move forms. Compares write their 0/1 result into it, and two add variants use it as their source or their destination. The signed immediate is the addend for the arithmetic forms. For the shift forms it also gives the direction: a non-negative count shifts left and a negative count shifts right. One parameter chooses how the address-register move extends its immediate.

A debug read port returns any register of either file without side effects. An unknown opcode is flagged in the same cycle and leaves both files untouched.

Top module: `simm_exec`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every register in both files becomes zero. `dbg_file_i`=0 selects the data file and 1 selects the address file, and `dbg_data_o` shows the register at `dbg_idx_i` combinationally.
- R2: The instruction layout is opcode in [7:0], index r in [11:8] and immediate in [15:12]. The immediate is sign-extended to 32 bits. Opcode 8'h10 (ADD) writes D[r]+imm to D[r] at the clock edge where `valid_i` is high.
- R3: Opcode 8'h11 writes D[r]+imm to D15. Opcode 8'h12 writes D15+imm to D[r].
- R4: Opcode 8'h13 writes A[r]+imm to A[r] and leaves the data file unchanged.
- R5: Opcode 8'h14 writes D[r]+imm to D[r] only when D15≠0. Opcode 8'h15 does the same only when D15=0. In all other cases D[r] keeps its value.
- R6: Opcode 8'h16 loads the sign-extended imm into D[r] only when D15=0. Opcode 8'h17 does so only when D15≠0.
- R7: Opcode 8'h18 writes 1 to D15 if D[r] equals imm and 0 otherwise. Opcode 8'h19 writes 1 to D15 if D[r] is less than imm as a signed value and 0 otherwise.
- R8: Opcode 8'h1A loads the sign-extended imm into D[r]. Opcode 8'h1B loads imm into A[r], sign-extended when `MOVA_SEXT`=1 (the default) and zero-extended when it is 0.
- R9: Opcode 8'h1C shifts D[r] by the signed imm: left by imm if imm≥0, and logically right by −imm if imm<0.
- R10: Opcode 8'h1D behaves like 8'h1C, except that a negative count shifts right arithmetically and copies bit 31 into the vacated bits.
- R11: With `valid_i` high and any other opcode, `illegal_o` is high in the same cycle and no register is written.
- R12: With `valid_i` low, no register is written and `illegal_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction word |
| illegal_o | output | 1 | Unknown opcode with valid high |
| dbg_file_i | input | 1 | Debug file select: 0 data, 1 address |
| dbg_idx_i | input | 4 | Debug register index |
| dbg_data_o | output | 32 | Debug read data |

## Verification
A wrong decode, a wrong extension or a wrong shift direction corrupts one register on the edge that executes the instruction. The debug port is pointed at that destination, so the corruption shows up one edge after the instruction is issued. A conditional form taking the wrong path shows up as a changed value where the old one was expected, or the reverse. A stray write into the other file or into D15 shows up when a later instruction reads that register, because the bench's running model then disagrees with the value the design produces.

// File: rtl/simm_pkg.sv
package simm_pkg;
  localparam int XLEN = 32;
  localparam int IMMW = 4;
  localparam int IDXW = 4;
  localparam int NREG = 1 << IDXW;

  typedef enum logic [3:0] {
    K_NONE, K_ADD, K_ADD_TO15, K_ADD_FROM15, K_ADDA, K_CADD, K_CADDN,
    K_CMOV, K_CMOVN, K_EQ, K_LT, K_MOV, K_MOVA, K_SH, K_SHA
  } kind_e;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext_imm(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){1'b0}}, v};
  endfunction

  // signed count: >=0 left, <0 right by magnitude; arith picks fill bit
  function automatic logic [XLEN-1:0] shift_by(input logic [XLEN-1:0] x,
                                               input logic [IMMW-1:0] cnt,
                                               input logic arith);
    logic [IMMW-1:0] mag;
    if (!cnt[IMMW-1]) return x << cnt;
    mag = ~cnt + 1'b1;
    if (arith) return XLEN'($signed(x) >>> mag);
    return x >> mag;
  endfunction
endpackage

// File: rtl/simm_decode.sv
module simm_decode
  import simm_pkg::*;
#(
  parameter logic [7:0] OP_ADD       = 8'h10,
  parameter logic [7:0] OP_ADD_TO15  = 8'h11,
  parameter logic [7:0] OP_ADD_FROM15 = 8'h12,
  parameter logic [7:0] OP_ADDA      = 8'h13,
  parameter logic [7:0] OP_CADD      = 8'h14,
  parameter logic [7:0] OP_CADDN     = 8'h15,
  parameter logic [7:0] OP_CMOV      = 8'h16,
  parameter logic [7:0] OP_CMOVN     = 8'h17,
  parameter logic [7:0] OP_EQ        = 8'h18,
  parameter logic [7:0] OP_LT        = 8'h19,
  parameter logic [7:0] OP_MOV       = 8'h1A,
  parameter logic [7:0] OP_MOVA      = 8'h1B,
  parameter logic [7:0] OP_SH        = 8'h1C,
  parameter logic [7:0] OP_SHA       = 8'h1D
) (
  input  logic [7:0] opcode_i,
  output kind_e      kind_o
);
  always_comb begin
    kind_o = K_NONE;
    if      (opcode_i == OP_ADD)        kind_o = K_ADD;
    else if (opcode_i == OP_ADD_TO15)   kind_o = K_ADD_TO15;
    else if (opcode_i == OP_ADD_FROM15) kind_o = K_ADD_FROM15;
    else if (opcode_i == OP_ADDA)       kind_o = K_ADDA;
    else if (opcode_i == OP_CADD)       kind_o = K_CADD;
    else if (opcode_i == OP_CADDN)      kind_o = K_CADDN;
    else if (opcode_i == OP_CMOV)       kind_o = K_CMOV;
    else if (opcode_i == OP_CMOVN)      kind_o = K_CMOVN;
    else if (opcode_i == OP_EQ)         kind_o = K_EQ;
    else if (opcode_i == OP_LT)         kind_o = K_LT;
    else if (opcode_i == OP_MOV)        kind_o = K_MOV;
    else if (opcode_i == OP_MOVA)       kind_o = K_MOVA;
    else if (opcode_i == OP_SH)         kind_o = K_SH;
    else if (opcode_i == OP_SHA)        kind_o = K_SHA;
  end
endmodule

// File: rtl/simm_regfile.sv
module simm_regfile #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int NRD  = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [IW-1:0]            widx_i,
  input  logic [XLEN-1:0]          wdata_i,
  input  logic [NRD-1:0][IW-1:0]   rd_idx_i,
  output logic [NRD-1:0][XLEN-1:0] rd_data_o
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[widx_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = mem[rd_idx_i[g]];
  end
endmodule

// File: rtl/simm_core.sv
module simm_core
  import simm_pkg::*;
#(
  parameter bit MOVA_SEXT = 1'b1
) (
  input  logic            valid_i,
  input  kind_e           kind_i,
  input  logic [IDXW-1:0] ridx_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] d_r_i,
  input  logic [XLEN-1:0] d15_i,
  input  logic [XLEN-1:0] a_r_i,
  output logic            d_we_o,
  output logic [IDXW-1:0] d_widx_o,
  output logic [XLEN-1:0] d_wdata_o,
  output logic            a_we_o,
  output logic [XLEN-1:0] a_wdata_o,
  output logic            cmp_o
);
  localparam logic [IDXW-1:0] IDX15 = IDXW'(NREG - 1);

  logic [XLEN-1:0] imm_s;
  logic            d15_nz;
  logic            want_d, want_a;

  assign imm_s  = sext_imm(imm_i);
  assign d15_nz = |d15_i;

  always_comb begin
    want_d    = 1'b0;
    want_a    = 1'b0;
    d_widx_o  = ridx_i;
    d_wdata_o = '0;
    a_wdata_o = '0;
    cmp_o     = 1'b0;
    case (kind_i)
      K_ADD:        begin want_d = 1'b1; d_wdata_o = d_r_i + imm_s; end
      K_ADD_TO15:   begin want_d = 1'b1; d_widx_o = IDX15; d_wdata_o = d_r_i + imm_s; end
      K_ADD_FROM15: begin want_d = 1'b1; d_wdata_o = d15_i + imm_s; end
      K_ADDA:       begin want_a = 1'b1; a_wdata_o = a_r_i + imm_s; end
      K_CADD:       begin want_d = d15_nz;  d_wdata_o = d_r_i + imm_s; end
      K_CADDN:      begin want_d = !d15_nz; d_wdata_o = d_r_i + imm_s; end
      K_CMOV:       begin want_d = !d15_nz; d_wdata_o = imm_s; end
      K_CMOVN:      begin want_d = d15_nz;  d_wdata_o = imm_s; end
      K_EQ: begin
        want_d = 1'b1; cmp_o = 1'b1; d_widx_o = IDX15;
        d_wdata_o = XLEN'(d_r_i == imm_s);
      end
      K_LT: begin
        want_d = 1'b1; cmp_o = 1'b1; d_widx_o = IDX15;
        d_wdata_o = XLEN'($signed(d_r_i) < $signed(imm_s));
      end
      K_MOV:  begin want_d = 1'b1; d_wdata_o = imm_s; end
      K_MOVA: begin
        want_a = 1'b1;
        a_wdata_o = MOVA_SEXT ? imm_s : zext_imm(imm_i);
      end
      K_SH:   begin want_d = 1'b1; d_wdata_o = shift_by(d_r_i, imm_i, 1'b0); end
      K_SHA:  begin want_d = 1'b1; d_wdata_o = shift_by(d_r_i, imm_i, 1'b1); end
      default: ;
    endcase
  end

  assign d_we_o = valid_i && want_d;
  assign a_we_o = valid_i && want_a;
endmodule

// File: rtl/simm_exec.sv
module simm_exec
  import simm_pkg::*;
#(
  parameter bit MOVA_SEXT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [15:0] instr_i,
  output logic        illegal_o,
  input  logic        dbg_file_i,
  input  logic [3:0]  dbg_idx_i,
  output logic [31:0] dbg_data_o
);
  localparam logic [IDXW-1:0] IDX15 = IDXW'(NREG - 1);

  kind_e                     kind;
  logic [IDXW-1:0]           ridx;
  logic [IMMW-1:0]           imm;
  logic [2:0][XLEN-1:0]      d_rd;
  logic [1:0][XLEN-1:0]      a_rd;
  logic [XLEN-1:0]           d_r_q, d15_q, a_r_q;
  logic                      d_we, a_we, cmp_op;
  logic [IDXW-1:0]           d_widx;
  logic [XLEN-1:0]           d_wdata, a_wdata;

  assign ridx = instr_i[11:8];
  assign imm  = instr_i[15:12];

  simm_decode u_dec (.opcode_i(instr_i[7:0]), .kind_o(kind));

  simm_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(3)) u_dfile (
    .clk(clk), .rst_n(rst_n), .we_i(d_we), .widx_i(d_widx), .wdata_i(d_wdata),
    .rd_idx_i({dbg_idx_i, IDX15, ridx}), .rd_data_o(d_rd)
  );

  simm_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(2)) u_afile (
    .clk(clk), .rst_n(rst_n), .we_i(a_we), .widx_i(ridx), .wdata_i(a_wdata),
    .rd_idx_i({dbg_idx_i, ridx}), .rd_data_o(a_rd)
  );

  assign d_r_q = d_rd[0];
  assign d15_q = d_rd[1];
  assign a_r_q = a_rd[0];

  simm_core #(.MOVA_SEXT(MOVA_SEXT)) u_core (
    .valid_i(valid_i), .kind_i(kind), .ridx_i(ridx), .imm_i(imm),
    .d_r_i(d_r_q), .d15_i(d15_q), .a_r_i(a_r_q),
    .d_we_o(d_we), .d_widx_o(d_widx), .d_wdata_o(d_wdata),
    .a_we_o(a_we), .a_wdata_o(a_wdata), .cmp_o(cmp_op)
  );

  assign illegal_o  = valid_i && (kind == K_NONE);
  assign dbg_data_o = dbg_file_i ? a_rd[1] : d_rd[2];
endmodule

// File: rtl/simm_exec_chk.sv
module simm_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic        illegal_o,
  input logic        d_we,
  input logic        a_we,
  input logic        cmp_op,
  input logic [31:0] d15_q
);
  p_illegal_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!d_we && !a_we));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!d_we && !a_we && !illegal_o));

  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({d_we, a_we, illegal_o}));

  p_cmp_boolean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cmp_op) |=> (d15_q <= 32'd1));
endmodule

bind simm_exec simm_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .illegal_o(illegal_o),
  .d_we(d_we), .a_we(a_we), .cmp_op(cmp_op), .d15_q(d15_q)
);

// File: tb/simm_exec_tb.sv
module simm_exec_tb;
  localparam logic [7:0] C_ADD = 8'h10, C_ADDT = 8'h11, C_ADDF = 8'h12,
    C_ADDA = 8'h13, C_CADD = 8'h14, C_CADDN = 8'h15, C_CMOV = 8'h16,
    C_CMOVN = 8'h17, C_EQ = 8'h18, C_LT = 8'h19, C_MOV = 8'h1A,
    C_MOVA = 8'h1B, C_SH = 8'h1C, C_SHA = 8'h1D;
  localparam bit SEXT_A = 1'b1;

  logic clk = 0, rst_n = 0, valid_i = 0, dbg_file_i = 0;
  logic [15:0] instr_i = '0;
  logic [3:0]  dbg_idx_i = '0;
  logic        illegal_o;
  logic [31:0] dbg_data_o;

  int n_tests = 0, n_fail = 0;

  simm_exec #(.MOVA_SEXT(SEXT_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .illegal_o(illegal_o), .dbg_file_i(dbg_file_i), .dbg_idx_i(dbg_idx_i),
    .dbg_data_o(dbg_data_o)
  );

  always #2 clk = ~clk;

  typedef struct { logic [31:0] val; logic ill; string tag; logic [7:0] op; } item_t;
  item_t sbq[$];
  logic [31:0] md [16];
  logic [31:0] ma [16];

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      C_ADD: return "R2";   C_ADDT, C_ADDF: return "R3";  C_ADDA: return "R4";
      C_CADD, C_CADDN: return "R5"; C_CMOV, C_CMOVN: return "R6";
      C_EQ, C_LT: return "R7"; C_MOV, C_MOVA: return "R8";
      C_SH: return "R9"; C_SHA: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input int r, input int imm);
    item_t it;
    logic [31:0] x, s;
    int sc;
    logic dfile;
    int obs;
    @(negedge clk);
    s = 32'(imm);
    x = md[r];
    sc = imm;
    dfile = 0; obs = r; it.ill = 0;
    case (op)
      C_ADD:   md[r] = x + s;
      C_ADDT:  begin md[15] = x + s; obs = 15; end
      C_ADDF:  md[r] = md[15] + s;
      C_ADDA:  begin ma[r] = ma[r] + s; dfile = 1; end
      C_CADD:  if (md[15] != 0) md[r] = x + s;
      C_CADDN: if (md[15] == 0) md[r] = x + s;
      C_CMOV:  if (md[15] == 0) md[r] = s;
      C_CMOVN: if (md[15] != 0) md[r] = s;
      C_EQ:    begin md[15] = (x == s) ? 1 : 0; obs = 15; end
      C_LT:    begin md[15] = ($signed(x) < $signed(s)) ? 1 : 0; obs = 15; end
      C_MOV:   md[r] = s;
      C_MOVA:  begin ma[r] = SEXT_A ? s : (s & 32'hF); dfile = 1; end
      C_SH:    md[r] = (sc >= 0) ? (x << sc) : (x >> (-sc));
      C_SHA:   md[r] = (sc >= 0) ? (x << sc) : 32'($signed(x) >>> (-sc));
      default: it.ill = 1;
    endcase
    it.val = dfile ? ma[obs] : md[obs];
    it.tag = tag_of(op);
    it.op  = op;
    instr_i = {4'(imm), 4'(r), op};
    valid_i = 1;
    dbg_file_i = dfile;
    dbg_idx_i = 4'(obs);
    sbq.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 0;
  endtask

  // monitor: one edge after issue, destination must hold the new value
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (valid_i && sbq.size() > 0) begin
        it = sbq.pop_front();
        check({it.tag, " value"}, dbg_data_o, it.val);
        check({it.tag, " illegal flag"}, {31'b0, illegal_o}, {31'b0, it.ill});
      end
    end
  end

  task automatic load_d(input int r, input logic [31:0] v);
    logic [32:0] w;
    w = {1'b0, v};
    issue(C_MOV, r, 0);
    for (int k = 10; k >= 0; k--) begin
      issue(C_SH, r, 3);
      issue(C_ADD, r, int'((w >> (3*k)) & 33'h7));
    end
  endtask

  task automatic load_a(input int r);
    issue(C_MOVA, r, int'($urandom_range(15)) - 8);
    for (int k = 0; k < 4; k++) issue(C_ADDA, r, int'($urandom_range(15)) - 8);
  endtask

  task automatic read_reg(input logic f, input int idx, input string tag, input logic [31:0] exp);
    @(negedge clk);
    valid_i = 0;
    dbg_file_i = f;
    dbg_idx_i = 4'(idx);
    #1;
    check(tag, dbg_data_o, exp);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ops [14];
    ops = '{C_ADD, C_ADDT, C_ADDF, C_ADDA, C_CADD, C_CADDN, C_CMOV,
            C_CMOVN, C_EQ, C_LT, C_MOV, C_MOVA, C_SH, C_SHA};
    for (int i = 0; i < 16; i++) begin md[i] = '0; ma[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: all registers zero after reset
    for (int i = 0; i < 16; i++) begin
      read_reg(0, i, "R1 data reset", 32'h0);
      read_reg(1, i, "R1 addr reset", 32'h0);
    end
    foreach (ops[o]) begin
      for (int imm = -8; imm <= 7; imm++) begin
        int r;
        logic [31:0] v;
        r = int'($urandom_range(15));
        v = $urandom;
        if ((ops[o] == C_EQ || ops[o] == C_LT) && ($urandom_range(2) == 0))
          v = 32'(imm) + 32'($urandom_range(1));
        if (r != 15) load_d(15, (imm % 2 == 0) ? 32'h0 : $urandom);
        load_d(r, v);
        if (ops[o] == C_ADDA || ops[o] == C_MOVA) load_a(r);
        issue(ops[o], r, imm);
      end
    end
    // R11: unknown opcodes flag and write nothing
    issue(8'hFF, 3, 5);
    issue(8'h00, 7, -1);
    issue(8'h1E, 15, 2);
    issue(8'h0F, 0, -8);
    idle();
    // R12: valid low leaves registers alone and keeps flag low
    load_d(4, 32'hDEAD_BEEF);
    @(negedge clk);
    valid_i = 0;
    instr_i = {4'd1, 4'd4, C_MOV};
    dbg_file_i = 0;
    dbg_idx_i = 4'd4;
    @(posedge clk);
    #1;
    check("R12 no write", dbg_data_o, md[4]);
    check("R12 illegal low", {31'b0, illegal_o}, 32'h0);
    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    read_reg(0, 4, "R1 data cleared", 32'h0);
    read_reg(0, 15, "R1 d15 cleared", 32'h0);
    read_reg(1, 2, "R1 addr cleared", 32'h0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule